// File: doc/BRIEF.md
# Dual-Reload PWM Timer

This block is a down-counting timer that produces a pulse-width-modulated waveform with no processor involvement once it is started. Two reload registers hold the lengths of the two output phases. Each time the counter underflows, the sequencer loads one of the two registers into the counter, alternating between them, and it can toggle the output level. Software writes the reload values and the control settings through a small register-write port. After that it only needs to act when it wants a different duty cycle or period.

Each reload source has its own sticky pending flag and its own interrupt enable. Software can therefore ask for an interrupt on the rising PWM edge, on the falling edge, on both, or on neither. A prescaled tick input sets the counting rate. The prescaler and any bus decoding sit outside this block.

Top module: `dual_reload_pwm_timer`

## Requirements
- R1: After reset the timer is stopped, `pwm_out` is 0 and `irq` is 0.
- R2: While running (control bit 0 = 1), the counter changes only on a cycle with `tick` high. While stopped, `tick` has no effect on the counter or on `pwm_out`.
- R3: A stopped timer holds its counter at zero. The first tick after start therefore underflows at once and loads reload A. A phase loaded from a value N lasts N+1 ticks.
- R4: Underflows after the first one load B, then A, then B, and so on, strictly alternating.
- R5: With toggle enable (control bit 1) set, every underflow inverts `pwm_out`. With it clear, underflows leave `pwm_out` unchanged.
- R6: An underflow that loads reload A sets flag A. An underflow that loads reload B sets flag B.
- R7: A flag stays set until it is cleared by a write to address 3 (bit 0 clears A, bit 1 clears B). A set in the same cycle as a clear wins.
- R8: `irq` = (flag A AND enable A) OR (flag B AND enable B). Enable A is control bit 2 and enable B is control bit 3.
- R9: Writing control bit 0 = 0 stops counting and resets the sequencer, so the next start loads A first again.
- R10: Address 0 writes reload A and address 1 writes reload B, at any time. A new value takes effect at the next reload from that register and does not shorten the phase in progress.
- R11: A write to address 3 with bit 2 set presets `pwm_out` to bit 3, but only while the timer is stopped. While running, the preset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable, one cycle per count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 reload A, 1 reload B, 2 control, 3 command |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM output level |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every pairing of small reload values, including zero. It compares the output against a closed-form phase position modulo A+B+2. A timer whose counter did not start at zero, or that lost a tick at each reload, would drift off this pattern within one period. Targeted sequences cover the remaining corner cases. A sequencer that is not reset on stop would load B first after a restart. A flag clear that beats a simultaneous set would drop an interrupt. A reload rewrite that applied at once would cut the current phase short. A preset that leaked into running operation would glitch the output.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
   // register-write address map
   typedef enum logic [1:0] {
      ADDR_RLD_A = 2'd0,
      ADDR_RLD_B = 2'd1,
      ADDR_CTRL  = 2'd2,
      ADDR_CMD   = 2'd3
   } pwm_addr_e;

   // control register fields
   typedef struct packed {
      logic en_b;
      logic en_a;
      logic tog_en;
      logic run;
   } pwm_ctrl_t;

   // reload source selected by the sequencer
   typedef enum logic {
      SRC_A = 1'b0,
      SRC_B = 1'b1
   } pwm_src_e;

   localparam int unsigned CMD_CLR_A   = 0;
   localparam int unsigned CMD_CLR_B   = 1;
   localparam int unsigned CMD_PRESET  = 2;
   localparam int unsigned CMD_LEVEL   = 3;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_tmr_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter logic [CNT_W-1:0] RLD_RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rld_a,
   output logic [CNT_W-1:0] rld_b,
   output pwm_ctrl_t        ctrl,
   output logic [1:0]       clr,
   output logic             preset_stb,
   output logic             preset_lvl
);
   localparam int unsigned CTRL_W = $bits(pwm_ctrl_t);

   generate
      if (CNT_W < CTRL_W) begin : g_width_bad
         $error("pwm_regs: CNT_W must hold the control and command fields");
      end
   endgenerate

   pwm_addr_e addr;
   logic      cmd_wr;

   assign addr   = pwm_addr_e'(wr_addr);
   assign cmd_wr = wr_en && (addr == ADDR_CMD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rld_a <= RLD_RESET;
         rld_b <= RLD_RESET;
         ctrl  <= '0;
      end else if (wr_en) begin
         unique case (addr)
            ADDR_RLD_A: rld_a <= wr_data;
            ADDR_RLD_B: rld_b <= wr_data;
            ADDR_CTRL:  ctrl  <= pwm_ctrl_t'(wr_data[CTRL_W-1:0]);
            default:    ;
         endcase
      end
   end

   // command writes are single-cycle strobes
   assign clr[0]     = cmd_wr && wr_data[CMD_CLR_A];
   assign clr[1]     = cmd_wr && wr_data[CMD_CLR_B];
   assign preset_stb = cmd_wr && wr_data[CMD_PRESET];
   assign preset_lvl = wr_data[CMD_LEVEL];

   // R1
   ctrl_reset_chk: assert property (@(posedge clk) !rst_n |=> ctrl == '0);
endmodule

// File: rtl/pwm_count.sv
module pwm_count
   import pwm_tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] rld_a,
   input  logic [CNT_W-1:0] rld_b,
   output logic             uf,
   output logic             uf_src
);
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   pwm_src_e         sel_q;

   assign uf     = run && tick && (cnt_q == CNT_ZERO);
   assign uf_src = sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= CNT_ZERO;
         sel_q <= SRC_A;
      end else if (tick) begin
         if (cnt_q == CNT_ZERO) begin
            cnt_q <= (sel_q == SRC_A) ? rld_a : rld_b;
            sel_q <= (sel_q == SRC_A) ? SRC_B : SRC_A;
         end else begin
            cnt_q <= cnt_q - CNT_ONE;
         end
      end
   end

   // R2
   cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && tick && cnt_q != CNT_ZERO |=> cnt_q == $past(cnt_q) - CNT_ONE);
   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !tick |=> $stable(cnt_q));
   // R4
   seq_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf |=> sel_q != $past(sel_q));
   // R3
   load_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf && sel_q == SRC_A |=> cnt_q == $past(rld_a));
   // R9
   stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt_q == CNT_ZERO && sel_q == SRC_A);
endmodule

// File: rtl/pwm_irq.sv
module pwm_irq #(
   parameter int unsigned NSRC    = 2,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            uf,
   input  logic            uf_src,
   input  logic [NSRC-1:0] clr,
   input  logic [NSRC-1:0] en,
   output logic [NSRC-1:0] flags,
   output logic            irq
);
   generate
      if (NSRC != 2) begin : g_nsrc_bad
         $error("pwm_irq: the reload sequencer has exactly two sources");
      end
   endgenerate

   logic irq_raw;

   for (genvar i = 0; i < NSRC; i++) begin : g_flag
      logic set_i;
      assign set_i = uf && (uf_src == 1'(i));

      always_ff @(posedge clk) begin
         if (!rst_n)        flags[i] <= 1'b0;
         else if (set_i)    flags[i] <= 1'b1;
         else if (clr[i])   flags[i] <= 1'b0;
      end

      // R6
      flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flags[i]) |-> $past(uf) && $past(uf_src) == 1'(i));
      // R7
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flags[i] && !clr[i] |=> flags[i]);
   end

   assign irq_raw = |(flags & en);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_raw;
      end
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & en) == '0 |-> ##(IRQ_REG ? 1 : 0) !irq);
endmodule

// File: rtl/dual_reload_pwm_timer.sv
module dual_reload_pwm_timer
   import pwm_tmr_pkg::*;
#(
   parameter int unsigned      CNT_W     = 16,
   parameter logic [CNT_W-1:0] RLD_RESET = '0,
   parameter bit               IRQ_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out,
   output logic             irq
);
   localparam int unsigned NSRC = 2;

   logic [CNT_W-1:0] rld_a;
   logic [CNT_W-1:0] rld_b;
   pwm_ctrl_t        ctrl;
   logic [NSRC-1:0]  clr;
   logic [NSRC-1:0]  flags;
   logic             preset_stb;
   logic             preset_lvl;
   logic             uf;
   logic             uf_src;

   pwm_regs #(.CNT_W(CNT_W), .RLD_RESET(RLD_RESET)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rld_a      (rld_a),
      .rld_b      (rld_b),
      .ctrl       (ctrl),
      .clr        (clr),
      .preset_stb (preset_stb),
      .preset_lvl (preset_lvl)
   );

   pwm_count #(.CNT_W(CNT_W)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ctrl.run),
      .tick   (tick),
      .rld_a  (rld_a),
      .rld_b  (rld_b),
      .uf     (uf),
      .uf_src (uf_src)
   );

   pwm_irq #(.NSRC(NSRC), .IRQ_REG(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .uf     (uf),
      .uf_src (uf_src),
      .clr    (clr),
      .en     ({ctrl.en_b, ctrl.en_a}),
      .flags  (flags),
      .irq    (irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwm_out <= 1'b0;
      end else if (ctrl.run) begin
         if (uf && ctrl.tog_en) pwm_out <= ~pwm_out;
      end else if (preset_stb) begin
         pwm_out <= preset_lvl;
      end
   end

   // R5
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.run && !(uf && ctrl.tog_en) |=> $stable(pwm_out));
   // R5
   out_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf && ctrl.tog_en |=> pwm_out != $past(pwm_out));
   // R2
   stopped_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.run && !preset_stb |=> $stable(pwm_out));
endmodule

// File: tb/tb_dual_reload_pwm_timer.sv
`timescale 1ns/1ps
module tb_dual_reload_pwm_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        pwm_out;
   logic        irq;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   dual_reload_pwm_timer dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq)
   );

   task automatic chk(input string req, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic tk();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   // stop, preset low, clear flags, load reloads, start with given control
   task automatic restart(input int a, input int b, input logic [3:0] c);
      wr(2'd2, 16'h0);
      wr(2'd3, 16'h0007);
      wr(2'd0, 16'(a));
      wr(2'd1, 16'(b));
      wr(2'd2, {12'h0, c});
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: got hung expected finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int vals[4] = '{0, 1, 2, 5};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 pwm_out", pwm_out, 1'b0);
      chk("R1 irq", irq, 1'b0);

      // R3 R4: sweep reload pairs, level from phase position mod A+B+2
      foreach (vals[i]) foreach (vals[j]) begin
         int a = vals[i];
         int b = vals[j];
         int p = a + b + 2;
         restart(a, b, 4'b0011);
         chk("R3 before first tick", pwm_out, 1'b0);
         for (int k = 1; k <= 2 * p + 1; k++) begin
            tk();
            chk("R4 waveform", pwm_out, ((k - 1) % p) < (a + 1));
         end
      end

      // R2: ticks while stopped do nothing
      wr(2'd2, 16'h0);
      wr(2'd3, 16'h000C);
      repeat (4) tk();
      chk("R2 stopped ticks", pwm_out, 1'b1);

      // R6 R7 R8 with A=2, B=3 (period 7)
      restart(2, 3, 4'b0111);
      tk();
      chk("R6 flag A on first underflow", irq, 1'b1);
      wr(2'd3, 16'h0001);
      chk("R7 clear A", irq, 1'b0);
      repeat (3) tk();  // ticks 2..4, tick 4 loads B
      chk("R6 B underflow not on A", irq, 1'b0);
      wr(2'd2, 16'h000B);
      chk("R6 flag B held", irq, 1'b1);
      wr(2'd2, 16'h000F);
      chk("R8 both enables", irq, 1'b1);
      wr(2'd3, 16'h0002);
      chk("R7 clear B", irq, 1'b0);
      repeat (4) tk();  // ticks 5..8, tick 8 loads A
      chk("R8 A edge irq", irq, 1'b1);
      wr(2'd3, 16'h0003);
      repeat (6) tk();  // ticks 9..14, B at tick 11
      wr(2'd2, 16'h0007);
      chk("R8 enable B off masks B", irq, 1'b0);
      @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0001;
      @(negedge clk); tick = 1'b0; wr_en = 1'b0;
      chk("R7 set beats clear", irq, 1'b1);

      // R5: toggle disabled
      restart(1, 1, 4'b0001);
      repeat (8) tk();
      chk("R5 no toggle", pwm_out, 1'b0);

      // R11: preset while stopped, ignored while running
      wr(2'd2, 16'h0);
      wr(2'd3, 16'h000C);
      chk("R11 preset high", pwm_out, 1'b1);
      wr(2'd2, 16'h0003);
      wr(2'd3, 16'h0004);
      chk("R11 preset ignored running", pwm_out, 1'b1);
      tk();
      chk("R11 toggle from preset", pwm_out, 1'b0);

      // R9: stop mid-phase, restart loads A first
      restart(3, 3, 4'b0011);
      tk(); tk();
      wr(2'd2, 16'h0);
      wr(2'd3, 16'h0004);
      wr(2'd2, 16'h0003);
      tk();
      chk("R9 restart first tick", pwm_out, 1'b1);
      repeat (3) tk();
      chk("R9 A phase length", pwm_out, 1'b1);
      tk();
      chk("R9 B load after A", pwm_out, 1'b0);

      // R10: rewrite A mid-phase, applies on next A reload
      restart(4, 2, 4'b0011);
      tk();
      wr(2'd0, 16'd1);
      repeat (4) tk();
      chk("R10 current phase kept", pwm_out, 1'b1);
      tk();
      chk("R10 B load", pwm_out, 1'b0);
      repeat (3) tk();
      chk("R10 A reload", pwm_out, 1'b1);
      tk();
      chk("R10 new A held", pwm_out, 1'b1);
      tk();
      chk("R10 new A length", pwm_out, 1'b0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule